// File: doc/BRIEF.md
# Shifted-Operand Recompute Error-Checked ALU

This block is a small bit-sliced ALU that checks its own answer. Each accepted operation is evaluated twice on the same slice chain. The first pass uses the operands as given. The second pass moves both operands up by `SHIFT` bit positions and moves the chain output back down by the same amount. The two aligned results are then compared. Any disagreement raises an error flag, and the flag works for both the logical operations and the addition.

The datapath is `WIDTH+SHIFT` slices wide. Operands are zero-extended, so neither the shifted operands nor the shifted result lose any bits. Every slice has a fault-injection point on its sum output and another on its carry output. A per-slice enable selects the slice. A forced value is given separately for each pass. This lets a test put any value on a slice output in either pass and measure how well the shift-and-compare scheme detects the fault.

Operations start with a one-cycle `start_i` while the block is idle. A `done_o` pulse returns the first-pass result, with `err_o` alongside it.

Top module: `shiftcheck_alu`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs `done_o`, `err_o` and `result_o` are all 0 after that edge.
- R2: A `start_i` sampled high in idle is answered by `done_o` high for exactly one cycle, three rising edges after the accepting edge. `result_o` then carries the first-pass result and holds it until the next `done_o`.
- R3: `opcode_i` is decoded as follows. 2'b00 is A OR B. 2'b01 is A AND B. 2'b10 is NOT A, and `b_i` is ignored. 2'b11 is A + B modulo 2^WIDTH, with a carry-in of 0 into slice 0.
- R4: With no fault enable bit set, `err_o` stays 0 for every operation.
- R5: `start_i` and any change to the operand, opcode or fault inputs have no effect while an operation is in progress. These inputs are captured only at the accepting edge.
- R6: Slice i is a bit of the `WIDTH+SHIFT`-wide chain, with slice 0 the LSB. If `sum_frc_i[i]` is set, the slice's sum output is replaced by `sum_p1_i[i]` in pass 1 and by `sum_p2_i[i]` in pass 2. The carry output into slice i+1 is treated the same way, using `cy_frc_i`, `cy_p1_i` and `cy_p2_i`. In pass 2, slice i processes operand bit i-SHIFT.
- R7: `err_o` is high together with `done_o` exactly when the low `WIDTH` bits of the first-pass result differ from those of the realigned second-pass result. `result_o` shows the first-pass value even when it is wrong.
- R8: For OR, AND and NOT, when all forced slices lie within `SHIFT` adjacent slices, a wrong `result_o` is always accompanied by `err_o`.
- R9: For ADD, when all forced slices lie within `SHIFT-1` adjacent slices, a wrong `result_o` is always accompanied by `err_o`.
- R10: Faults spanning `SHIFT` adjacent adder slices can escape detection. Take WIDTH=16, SHIFT=3, A=0x0FFF and B=0, with slices 0..2 forced. Pass 1 forces sum 0 and carry 1. Pass 2 forces sum 0 and carries 0,0,1. The result is 0x1000 with `err_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation (taken only in idle) |
| opcode_i | input | 2 | Operation select |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| sum_frc_i | input | WIDTH+SHIFT | Per-slice sum force enable |
| sum_p1_i | input | WIDTH+SHIFT | Forced sum values, pass 1 |
| sum_p2_i | input | WIDTH+SHIFT | Forced sum values, pass 2 |
| cy_frc_i | input | WIDTH+SHIFT | Per-slice carry force enable |
| cy_p1_i | input | WIDTH+SHIFT | Forced carry values, pass 1 |
| cy_p2_i | input | WIDTH+SHIFT | Forced carry values, pass 2 |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Mismatch flag, valid with `done_o` |
| result_o | output | WIDTH | First-pass result |

## Verification
The accepting edge is counted as edge 0. The first-pass result is registered at edge 1 and the realigned second-pass result at edge 2. `done_o`, `err_o` and `result_o` change at edge 3, so they can be observed in the half-cycle after it. The bench drives inputs on falling edges. It keeps a behavioural model that counts edges from the accepted start, and it compares all three outputs against that model at every falling edge. The directed checks for each requirement sample on the third falling edge after `start_i` is dropped, which is the first falling edge after edge 3.

// File: rtl/shiftcheck_pkg.sv
package shiftcheck_pkg;

  typedef enum logic [1:0] {
    OP_OR  = 2'b00,
    OP_AND = 2'b01,
    OP_NOT = 2'b10,
    OP_ADD = 2'b11
  } alu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_PASS1 = 2'b01,
    ST_PASS2 = 2'b10,
    ST_CMP   = 2'b11
  } seq_st_e;

endpackage

// File: rtl/shiftcheck_slice.sv
// One bit slice: logic function or full adder, with forcible outputs.
module shiftcheck_slice
  import shiftcheck_pkg::*;
(
  input  alu_op_e op_i,
  input  logic    a_i,
  input  logic    b_i,
  input  logic    cin_i,
  input  logic    sum_frc_i,
  input  logic    sum_val_i,
  input  logic    cy_frc_i,
  input  logic    cy_val_i,
  output logic    sum_o,
  output logic    cout_o
);

  logic raw_sum;
  logic raw_cy;

  always_comb begin
    raw_cy = 1'b0;
    case (op_i)
      OP_OR:   raw_sum = a_i | b_i;
      OP_AND:  raw_sum = a_i & b_i;
      OP_NOT:  raw_sum = ~a_i;
      default: begin
        raw_sum = a_i ^ b_i ^ cin_i;
        raw_cy  = (a_i & b_i) | (cin_i & (a_i ^ b_i));
      end
    endcase
  end

  // Fault injection points on both slice outputs (R6)
  assign sum_o  = sum_frc_i ? sum_val_i : raw_sum;
  assign cout_o = cy_frc_i  ? cy_val_i  : raw_cy;

endmodule

// File: rtl/shiftcheck_datapath.sv
// Input shifters, slice chain and realigning output shifter.
module shiftcheck_datapath
  import shiftcheck_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SHIFT = 3
) (
  input  alu_op_e                  op_i,
  input  logic [WIDTH-1:0]         a_i,
  input  logic [WIDTH-1:0]         b_i,
  input  logic                     pass2_i,
  input  logic [WIDTH+SHIFT-1:0]   sum_frc_i,
  input  logic [WIDTH+SHIFT-1:0]   sum_p1_i,
  input  logic [WIDTH+SHIFT-1:0]   sum_p2_i,
  input  logic [WIDTH+SHIFT-1:0]   cy_frc_i,
  input  logic [WIDTH+SHIFT-1:0]   cy_p1_i,
  input  logic [WIDTH+SHIFT-1:0]   cy_p2_i,
  output logic [WIDTH-1:0]         res_o
);

  localparam int DW = WIDTH + SHIFT;

  logic [DW-1:0] a_x, b_x;
  logic [DW-1:0] sum_v, cy_v;
  logic [DW-1:0] y;
  logic [DW:0]   cy;
  logic          unused_cy_top;

  // Left shifters: pass-through in pass 1, up by SHIFT in pass 2
  always_comb begin
    if (pass2_i) begin
      a_x = {a_i, {SHIFT{1'b0}}};
      b_x = {b_i, {SHIFT{1'b0}}};
    end else begin
      a_x = {{SHIFT{1'b0}}, a_i};
      b_x = {{SHIFT{1'b0}}, b_i};
    end
  end

  assign sum_v = pass2_i ? sum_p2_i : sum_p1_i;
  assign cy_v  = pass2_i ? cy_p2_i  : cy_p1_i;

  assign cy[0] = 1'b0;

  for (genvar i = 0; i < DW; i++) begin : g_slice
    shiftcheck_slice u_slice (
      .op_i      (op_i),
      .a_i       (a_x[i]),
      .b_i       (b_x[i]),
      .cin_i     (cy[i]),
      .sum_frc_i (sum_frc_i[i]),
      .sum_val_i (sum_v[i]),
      .cy_frc_i  (cy_frc_i[i]),
      .cy_val_i  (cy_v[i]),
      .sum_o     (y[i]),
      .cout_o    (cy[i+1])
    );
  end

  assign unused_cy_top = cy[DW];

  // Right shifter: realign the pass-2 output before it is kept
  assign res_o = pass2_i ? y[DW-1:SHIFT] : y[WIDTH-1:0];

endmodule

// File: rtl/shiftcheck_seq.sv
// Operation sequencer: idle, first pass, second pass, compare.
module shiftcheck_seq
  import shiftcheck_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic accept_o,
  output logic pass2_o,
  output logic grab1_o,
  output logic grab2_o,
  output logic fin_o
);

  seq_st_e st, st_nx;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:  if (start_i) st_nx = ST_PASS1;
      ST_PASS1: st_nx = ST_PASS2;
      ST_PASS2: st_nx = ST_CMP;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nx;
  end

  assign accept_o = (st == ST_IDLE) && start_i;
  assign pass2_o  = (st == ST_PASS2);
  assign grab1_o  = (st == ST_PASS1);
  assign grab2_o  = (st == ST_PASS2);
  assign fin_o    = (st == ST_CMP);

  // R2: the passes follow one another without stalls
  p_pass_order_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PASS1) |=> (st == ST_PASS2));

  // R5: a start seen mid-operation never restarts the sequence
  p_busy_start_r5: assert property (@(posedge clk) disable iff (rst)
    ((st != ST_IDLE) && start_i) |=> (st != ST_PASS1));

endmodule

// File: rtl/shiftcheck_alu.sv
module shiftcheck_alu
  import shiftcheck_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SHIFT = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic [1:0]             opcode_i,
  input  logic [WIDTH-1:0]       a_i,
  input  logic [WIDTH-1:0]       b_i,
  input  logic [WIDTH+SHIFT-1:0] sum_frc_i,
  input  logic [WIDTH+SHIFT-1:0] sum_p1_i,
  input  logic [WIDTH+SHIFT-1:0] sum_p2_i,
  input  logic [WIDTH+SHIFT-1:0] cy_frc_i,
  input  logic [WIDTH+SHIFT-1:0] cy_p1_i,
  input  logic [WIDTH+SHIFT-1:0] cy_p2_i,
  output logic                   done_o,
  output logic                   err_o,
  output logic [WIDTH-1:0]       result_o
);

  localparam int DW = WIDTH + SHIFT;

  logic accept, pass2, grab1, grab2, fin;

  alu_op_e          op_q;
  logic [WIDTH-1:0] a_q, b_q;
  logic [DW-1:0]    sfrc_q, sp1_q, sp2_q, cfrc_q, cp1_q, cp2_q;
  logic [WIDTH-1:0] r1_q, r2_q;
  logic [WIDTH-1:0] dp_res;

  shiftcheck_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .accept_o (accept),
    .pass2_o  (pass2),
    .grab1_o  (grab1),
    .grab2_o  (grab2),
    .fin_o    (fin)
  );

  // Capture the whole request at the accepting edge (R5)
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_OR;
      a_q    <= '0;
      b_q    <= '0;
      sfrc_q <= '0;
      sp1_q  <= '0;
      sp2_q  <= '0;
      cfrc_q <= '0;
      cp1_q  <= '0;
      cp2_q  <= '0;
    end else if (accept) begin
      op_q   <= alu_op_e'(opcode_i);
      a_q    <= a_i;
      b_q    <= b_i;
      sfrc_q <= sum_frc_i;
      sp1_q  <= sum_p1_i;
      sp2_q  <= sum_p2_i;
      cfrc_q <= cy_frc_i;
      cp1_q  <= cy_p1_i;
      cp2_q  <= cy_p2_i;
    end
  end

  shiftcheck_datapath #(
    .WIDTH (WIDTH),
    .SHIFT (SHIFT)
  ) u_dp (
    .op_i      (op_q),
    .a_i       (a_q),
    .b_i       (b_q),
    .pass2_i   (pass2),
    .sum_frc_i (sfrc_q),
    .sum_p1_i  (sp1_q),
    .sum_p2_i  (sp2_q),
    .cy_frc_i  (cfrc_q),
    .cy_p1_i   (cp1_q),
    .cy_p2_i   (cp2_q),
    .res_o     (dp_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      r1_q <= '0;
      r2_q <= '0;
    end else begin
      if (grab1) r1_q <= dp_res;
      if (grab2) r2_q <= dp_res;
    end
  end

  // Compare stage and registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      done_o   <= 1'b0;
      err_o    <= 1'b0;
      result_o <= '0;
    end else if (fin) begin
      done_o   <= 1'b1;
      err_o    <= (r1_q != r2_q);
      result_o <= r1_q;
    end else begin
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end
  end

  // R2: completion is a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R2: result holds between completions
  p_result_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !fin |=> $stable(result_o));

  // R7: the error flag only accompanies completion
  p_err_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    err_o |-> done_o);

  // R4: with no injection enabled the passes always agree
  p_clean_run_r4: assert property (@(posedge clk) disable iff (rst)
    (done_o && (sfrc_q == '0) && (cfrc_q == '0)) |-> !err_o);

endmodule

// File: tb/shiftcheck_alu_tb.sv
module shiftcheck_alu_tb;

  localparam int W  = 16;
  localparam int K  = 3;
  localparam int DW = W + K;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [1:0]    opcode_i = 2'b00;
  logic [W-1:0]  a_i = '0, b_i = '0;
  logic [DW-1:0] sum_frc_i = '0, sum_p1_i = '0, sum_p2_i = '0;
  logic [DW-1:0] cy_frc_i = '0, cy_p1_i = '0, cy_p2_i = '0;
  logic          done_o, err_o;
  logic [W-1:0]  result_o;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  shiftcheck_alu #(.WIDTH(W), .SHIFT(K)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .opcode_i(opcode_i),
    .a_i(a_i), .b_i(b_i),
    .sum_frc_i(sum_frc_i), .sum_p1_i(sum_p1_i), .sum_p2_i(sum_p2_i),
    .cy_frc_i(cy_frc_i), .cy_p1_i(cy_p1_i), .cy_p2_i(cy_p2_i),
    .done_o(done_o), .err_o(err_o), .result_o(result_o)
  );

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural model of both passes: returns {mismatch, pass-1 result}
  function automatic logic [W:0] ref_run(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
      input logic [DW-1:0] se, input logic [DW-1:0] s1, input logic [DW-1:0] s2,
      input logic [DW-1:0] ce, input logic [DW-1:0] c1, input logic [DW-1:0] c2);
    logic [W-1:0]  r [2];
    logic [DW-1:0] ax, bx, y, sv, cv;
    logic          c, s, nc;
    for (int p = 0; p < 2; p++) begin
      ax = {{K{1'b0}}, a} << (p * K);
      bx = {{K{1'b0}}, b} << (p * K);
      sv = (p == 1) ? s2 : s1;
      cv = (p == 1) ? c2 : c1;
      c  = 1'b0;
      for (int i = 0; i < DW; i++) begin
        nc = 1'b0;
        case (op)
          2'b00:   s = ax[i] | bx[i];
          2'b01:   s = ax[i] & bx[i];
          2'b10:   s = ~ax[i];
          default: begin
            s  = ax[i] ^ bx[i] ^ c;
            nc = (ax[i] & bx[i]) | (c & (ax[i] ^ bx[i]));
          end
        endcase
        if (se[i]) s = sv[i];
        if (ce[i]) nc = cv[i];
        y[i] = s;
        c = nc;
      end
      y = y >> (p * K);
      r[p] = y[W-1:0];
    end
    return {r[0] != r[1], r[0]};
  endfunction

  function automatic logic [W-1:0] golden(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    case (op)
      2'b00:   return a | b;
      2'b01:   return a & b;
      2'b10:   return ~a;
      default: return a + b;
    endcase
  endfunction

  // Cycle model: counts edges from the accepting edge
  bit           live = 0;
  bit           m_busy = 0;
  int           m_cnt = 0;
  logic [W:0]   m_pend;
  logic         exp_done = 0, exp_err = 0;
  logic [W-1:0] exp_res = '0;

  always @(posedge clk) begin
    live = 1;
    if (rst) begin
      m_busy = 0; exp_done = 0; exp_err = 0; exp_res = '0;
    end else begin
      exp_done = 0;
      exp_err  = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == 3) begin
          exp_done = 1;
          exp_err  = m_pend[W];
          exp_res  = m_pend[W-1:0];
          m_busy   = 0;
        end
      end else if (start_i) begin
        m_busy = 1;
        m_cnt  = 0;
        m_pend = ref_run(opcode_i, a_i, b_i, sum_frc_i, sum_p1_i, sum_p2_i, cy_frc_i, cy_p1_i, cy_p2_i);
      end
    end
  end

  always @(negedge clk) begin
    if (live) begin
      check(done_o === exp_done, "R2 done timing", {15'd0, done_o}, {15'd0, exp_done});
      check(err_o === exp_err, "R7 err per cycle", {15'd0, err_o}, {15'd0, exp_err});
      check(result_o === exp_res, "R2 result per cycle", result_o, exp_res);
    end
  end

  logic [W-1:0] got_res;
  logic         got_err;

  task automatic run(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
      input logic [DW-1:0] se, input logic [DW-1:0] s1, input logic [DW-1:0] s2,
      input logic [DW-1:0] ce, input logic [DW-1:0] c1, input logic [DW-1:0] c2);
    @(negedge clk);
    opcode_i = op; a_i = a; b_i = b;
    sum_frc_i = se; sum_p1_i = s1; sum_p2_i = s2;
    cy_frc_i = ce; cy_p1_i = c1; cy_p2_i = c2;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (2) @(negedge clk);
    @(negedge clk);
    got_res = result_o;
    got_err = err_o;
    check(done_o === 1'b1, "R2 done due", {15'd0, done_o}, 16'd1);
  endtask

  task automatic run_clean(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    run(op, a, b, '0, '0, '0, '0, '0, '0);
    check(got_res === golden(op, a, b), tag, got_res, golden(op, a, b));
    check(got_err === 1'b0, "R4 clean no error", {15'd0, got_err}, 16'd0);
  endtask

  logic [31:0] seed = 32'h1234_5678;
  function automatic logic [31:0] nxt(input logic [31:0] x);
    return x * 32'd1664525 + 32'd1013904223;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check(done_o === 1'b0, "R1 done reset", {15'd0, done_o}, 16'd0);
    check(err_o === 1'b0, "R1 err reset", {15'd0, err_o}, 16'd0);
    check(result_o === '0, "R1 result reset", result_o, 16'd0);
    rst = 1'b0;

    // R3: each opcode, fault-free
    run_clean(2'b00, 16'h1234, 16'h0F0F, "R3 OR");
    run_clean(2'b01, 16'hF0F0, 16'h3C3C, "R3 AND");
    run_clean(2'b10, 16'h00FF, 16'h1234, "R3 NOT");
    run_clean(2'b10, 16'h00FF, 16'hFFFF, "R3 NOT ignores B");
    run_clean(2'b11, 16'hFFFF, 16'h0001, "R3 ADD wrap");
    run_clean(2'b11, 16'h1234, 16'h4321, "R3 ADD");
    run_clean(2'b11, 16'h8000, 16'h8000, "R3 ADD top carry");

    // R5: start held high and inputs changed during the operation
    @(negedge clk);
    opcode_i = 2'b00; a_i = 16'h00F0; b_i = 16'h0F00; start_i = 1'b1;
    @(negedge clk);
    opcode_i = 2'b11; a_i = 16'hFFFF; b_i = 16'hFFFF; sum_frc_i = '1;
    @(negedge clk);
    @(negedge clk);
    start_i = 1'b0; sum_frc_i = '0;
    @(negedge clk);
    check(result_o === 16'h0FF0, "R5 busy inputs ignored", result_o, 16'h0FF0);
    check(err_o === 1'b0, "R5 no error", {15'd0, err_o}, 16'd0);
    @(negedge clk);
    check(done_o === 1'b0, "R5 no restart", {15'd0, done_o}, 16'd0);

    // R6/R7: pass-1-only sum fault on slice 4
    run(2'b00, 16'h0001, 16'h0000, 19'h10, 19'h10, 19'h00, '0, '0, '0);
    check(got_res === 16'h0011, "R6 pass1 sum forced", got_res, 16'h0011);
    check(got_err === 1'b1, "R7 pass1 fault flagged", {15'd0, got_err}, 16'd1);
    // R6/R7: pass-2-only sum fault on slice 4
    run(2'b00, 16'h0001, 16'h0000, 19'h10, 19'h00, 19'h10, '0, '0, '0);
    check(got_res === 16'h0001, "R7 result from pass1", got_res, 16'h0001);
    check(got_err === 1'b1, "R7 pass2 fault flagged", {15'd0, got_err}, 16'd1);
    // R6: carry fault out of slice 0 in both passes
    run(2'b11, 16'h0000, 16'h0000, '0, '0, '0, 19'h1, 19'h1, 19'h1);
    check(got_res === 16'h0002, "R6 carry forced", got_res, 16'h0002);
    check(got_err === 1'b1, "R7 carry fault flagged", {15'd0, got_err}, 16'd1);

    // R8: logical ops, faults inside SHIFT adjacent slices
    for (int n = 0; n < 40; n++) begin
      logic [1:0]    op;
      logic [DW-1:0] win, se, ce, s1, s2;
      logic [W-1:0]  a, b;
      seed = nxt(seed); op = 2'(seed[9:8] % 3);
      a = seed[31:16]; seed = nxt(seed); b = seed[31:16];
      win = ((DW'(1) << K) - 1) << (seed[7:0] % (DW - K + 1));
      seed = nxt(seed); se = win & DW'(seed[31:13] | 19'h1);
      s1 = DW'(seed[18:0]); seed = nxt(seed); s2 = DW'(seed[30:12]);
      ce = win & DW'(seed[20:2]);
      run(op, a, b, se, s1, s2, ce, s1, s2);
      check((got_res === golden(op, a, b)) || got_err, "R8 logical detection", got_res, golden(op, a, b));
    end

    // R9: ADD, faults inside SHIFT-1 adjacent slices
    for (int n = 0; n < 40; n++) begin
      logic [DW-1:0] win, se, ce, s1, s2, c1, c2;
      logic [W-1:0]  a, b;
      seed = nxt(seed); a = seed[31:16]; seed = nxt(seed); b = seed[31:16];
      win = ((DW'(1) << (K - 1)) - 1) << (seed[7:0] % (DW - K + 2));
      seed = nxt(seed); se = win & DW'(seed[31:13]); ce = win & DW'(seed[22:4]);
      s1 = DW'(seed[18:0]); seed = nxt(seed); s2 = DW'(seed[30:12]);
      c1 = DW'(seed[20:2]); seed = nxt(seed); c2 = DW'(seed[27:9]);
      run(2'b11, a, b, se, s1, s2, ce, c1, c2);
      check((got_res === golden(2'b11, a, b)) || got_err, "R9 adder detection", got_res, golden(2'b11, a, b));
    end

    // R10: escape with SHIFT adjacent faulty adder slices
    run(2'b11, 16'h0FFF, 16'h0000, 19'h7, 19'h0, 19'h0, 19'h7, 19'h7, 19'h4);
    check(got_res === 16'h1000, "R10 escape result", got_res, 16'h1000);
    check(got_err === 1'b0, "R10 escape undetected", {15'd0, got_err}, 16'd0);

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule